// File: doc/BRIEF.md
# Receive Timestamp Prepend Unit

This block sits in the receive frame path between the MAC and the packet parser. For each logical port it keeps an insertion switch. When the switch is on for the port a frame arrives on, the block captures the free-running precision time value as soon as the frame's first beat is offered. It then emits that 64-bit value as an 8-byte header, most significant byte first, ahead of the unchanged frame bytes. Frames on ports with the switch off pass through untouched.

The same switch sets two values the parser reads for each port. The first is a header skip length in 2-byte units, so the parser steps over the timestamp. The second is a maximum frame length, raised by 8 bytes so the extra header is not reported as an oversize frame. A new switch setting is written through a small control write port. It is applied only when no frame is in flight, so the header decision and the parser limits for a frame always agree. The stream interfaces on both sides are valid/ready with start and end markers and a byte-valid mask on the last beat. The beat width is a parameter that must divide 8 bytes, which covers byte and word streams.

Top module: `rx_ts_prepend`

## Requirements
- R1: When insertion is on for the frame's port, the output frame starts with 8 header bytes holding the time value sampled on the clock edge where the first input beat is first offered while the block is idle. The bytes go most significant byte first, and byte 0 of a beat is data[7:0]. The frame bytes follow unchanged.
- R2: When insertion is off for the frame's port, the output frame is byte for byte the input frame, with no header.
- R3: A control write sets the insertion switch of port cfgPort to bit 12 of cfgWdata. All other bits of cfgWdata have no effect, and a write to one port leaves the other ports unchanged.
- R4: The skip length of a port reads 4 (units of 2 bytes) while insertion is on and 0 while it is off.
- R5: The maximum frame length of a port is BASE_MAX_LEN after reset. It rises by 8 when the switch turns on and falls by 8 when it turns off. A write that repeats the current setting changes nothing.
- R6: A switch change takes effect only while no frame is in flight. During a frame the skip length and maximum length of every port stay constant, and the frame is built with the setting in force at its start.
- R7: One captured time value serves the whole frame, however long the output is stalled.
- R8: No output beat changes or disappears while it is stalled, and an input beat is taken only in a cycle where an output beat is taken.
- R9: outSof marks only the first output beat of a frame and outEof its last beat. outKeep on the last beat gives the valid bytes as contiguous ones from bit 0. Header beats are never last.
- R10: After reset no output beat is valid, every skip length is 0 and every maximum length is BASE_MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptpTime | input | 64 | Free-running precision time value |
| cfgWe | input | 1 | Control write strobe |
| cfgPort | input | PORT_W | Port addressed by the write |
| cfgWdata | input | 16 | Control word; bit 12 is the insertion switch |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted |
| inData | input | 8*DATA_BYTES | Input beat bytes |
| inKeep | input | DATA_BYTES | Input byte-valid mask (last beat) |
| inSof | input | 1 | First beat of input frame |
| inEof | input | 1 | Last beat of input frame |
| inPort | input | PORT_W | Logical port of the frame, held for the whole frame |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts output beat |
| outData | output | 8*DATA_BYTES | Output beat bytes |
| outKeep | output | DATA_BYTES | Output byte-valid mask (last beat) |
| outSof | output | 1 | First beat of output frame |
| outEof | output | 1 | Last beat of output frame |
| portSkipLen | output | 4*NUM_PORTS | Per-port parser skip length, port p at bits 4p+3:4p |
| portMaxLen | output | LEN_W*NUM_PORTS | Per-port maximum frame length, port p at slice p |

## Verification
The bench stalls the header under random and long backpressure while the time input keeps moving. A design that recaptured the time value, or that advanced the header index without a handshake, would show mixed or skipped timestamp bytes. It turns a port off while that port's frame is stalled in its header. A design that applied the change at once would move the parser limits in mid-frame or drop the header. It sends one-byte, odd-length and exact-beat frames, which expose wrong keep handling and a header beat marked last. It also repeats enable and disable writes and writes all-ones words with bit 12 clear. A design that adjusted the length limit on every write, or decoded the wrong bit, would drift by 8 or switch the wrong way.

// File: rtl/rx_ts_prepend_pkg.sv
package rx_ts_prepend_pkg;
  localparam int TS_BYTES = 8;
  localparam int TS_W     = 8 * TS_BYTES;
  localparam int CTRL_W   = 16;
  localparam int EN_BIT   = 12;
  localparam int SKIP_W   = 4;
  // skip length counted in 2-byte units
  localparam int SKIP_ON  = TS_BYTES / 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PASS = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic latchTs;     // capture time value, restart header index
    logic hdrAdvance;  // a header beat was taken downstream
    logic selHdr;      // output carries a header beat
    logic clearSof;    // suppress input start marker
  } dp_strobe_t;
endpackage

// File: rtl/rx_ts_port_cfg.sv
module rx_ts_port_cfg
  import rx_ts_prepend_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int PORT_W       = 2,
  parameter int LEN_W        = 16,
  parameter int BASE_MAX_LEN = 1518
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [PORT_W-1:0]           cfgPort,
  input  logic [CTRL_W-1:0]           cfgWdata,
  input  logic                        commitOk,
  output logic [NUM_PORTS-1:0]        portActive,
  output logic [NUM_PORTS*SKIP_W-1:0] portSkipLen,
  output logic [NUM_PORTS*LEN_W-1:0]  portMaxLen
);
  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfgWdata[CTRL_W-1:EN_BIT+1], cfgWdata[EN_BIT-1:0]};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic             reqEn;
    logic             actEn;
    logic [LEN_W-1:0] maxLen;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqEn  <= 1'b0;
        actEn  <= 1'b0;
        maxLen <= LEN_W'(BASE_MAX_LEN);
      end else begin
        if (cfgWe && cfgPort == PORT_W'(p)) reqEn <= cfgWdata[EN_BIT];
        // only a real transition moves the length limit
        if (commitOk && reqEn != actEn) begin
          actEn  <= reqEn;
          maxLen <= reqEn ? maxLen + LEN_W'(TS_BYTES) : maxLen - LEN_W'(TS_BYTES);
        end
      end
    end

    assign portActive[p]                    = actEn;
    assign portSkipLen[p*SKIP_W +: SKIP_W] = actEn ? SKIP_W'(SKIP_ON) : '0;
    assign portMaxLen[p*LEN_W +: LEN_W]    = maxLen;
  end
endmodule

// File: rtl/rx_ts_ctrl.sv
module rx_ts_ctrl
  import rx_ts_prepend_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       outReady,
  input  logic       portEn,
  input  logic       hdrLast,
  output logic       inReady,
  output logic       outValid,
  output logic       commitOk,
  output dp_strobe_t strobe
);
  ctrl_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    commitOk  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        commitOk = !(inValid && inSof);
        if (inValid && inSof && portEn) begin
          strobe.latchTs = 1'b1;
          stateNext      = ST_HDR;
        end else begin
          inReady  = outReady;
          outValid = inValid;
          if (inValid && outReady && inSof && !inEof) stateNext = ST_PASS;
        end
      end
      ST_HDR: begin
        outValid      = 1'b1;
        strobe.selHdr = 1'b1;
        if (outReady) begin
          strobe.hdrAdvance = 1'b1;
          if (hdrLast) stateNext = ST_PASS;
        end
      end
      ST_PASS: begin
        inReady         = outReady;
        outValid        = inValid;
        strobe.clearSof = 1'b1;
        if (inValid && outReady && inEof) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rx_ts_dpath.sv
module rx_ts_dpath
  import rx_ts_prepend_pkg::*;
#(
  parameter int DATA_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [TS_W-1:0]         ptpTime,
  input  dp_strobe_t              strobe,
  input  logic [8*DATA_BYTES-1:0] inData,
  input  logic [DATA_BYTES-1:0]   inKeep,
  input  logic                    inSof,
  input  logic                    inEof,
  output logic [8*DATA_BYTES-1:0] outData,
  output logic [DATA_BYTES-1:0]   outKeep,
  output logic                    outSof,
  output logic                    outEof,
  output logic                    hdrLast
);
  localparam int HDR_BEATS = TS_BYTES / DATA_BYTES;
  localparam int CNT_W     = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

  logic [TS_W-1:0]         tsReg;
  logic [CNT_W-1:0]        hdrIdx;
  logic [8*DATA_BYTES-1:0] hdrBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsReg  <= '0;
      hdrIdx <= '0;
    end else if (strobe.latchTs) begin
      tsReg  <= ptpTime;
      hdrIdx <= '0;
    end else if (strobe.hdrAdvance) begin
      hdrIdx <= hdrLast ? '0 : hdrIdx + 1'b1;
    end
  end

  assign hdrLast = (hdrIdx == CNT_W'(HDR_BEATS - 1));

  // most significant timestamp byte leaves first
  always_comb begin
    for (int j = 0; j < DATA_BYTES; j++) begin
      hdrBeat[8*j +: 8] = tsReg[TS_W - 8 - 8*(int'(hdrIdx)*DATA_BYTES + j) +: 8];
    end
  end

  always_comb begin
    if (strobe.selHdr) begin
      outData = hdrBeat;
      outKeep = '1;
      outSof  = (hdrIdx == '0);
      outEof  = 1'b0;
    end else begin
      outData = inData;
      outKeep = inKeep;
      outSof  = inSof && !strobe.clearSof;
      outEof  = inEof;
    end
  end
endmodule

// File: rtl/rx_ts_prepend.sv
module rx_ts_prepend
  import rx_ts_prepend_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int DATA_BYTES   = 2,
  parameter int LEN_W        = 16,
  parameter int BASE_MAX_LEN = 1518,
  localparam int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DATA_W      = 8 * DATA_BYTES
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [TS_W-1:0]             ptpTime,
  input  logic                        cfgWe,
  input  logic [PORT_W-1:0]           cfgPort,
  input  logic [CTRL_W-1:0]           cfgWdata,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [DATA_W-1:0]           inData,
  input  logic [DATA_BYTES-1:0]       inKeep,
  input  logic                        inSof,
  input  logic                        inEof,
  input  logic [PORT_W-1:0]           inPort,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [DATA_W-1:0]           outData,
  output logic [DATA_BYTES-1:0]       outKeep,
  output logic                        outSof,
  output logic                        outEof,
  output logic [NUM_PORTS*SKIP_W-1:0] portSkipLen,
  output logic [NUM_PORTS*LEN_W-1:0]  portMaxLen
);
  localparam int PAD_W = 2 ** PORT_W;

  logic [NUM_PORTS-1:0] portActive;
  logic [PAD_W-1:0]     portActivePad;
  logic                 portEn;
  logic                 commitOk;
  logic                 hdrLast;
  dp_strobe_t           strobe;

  assign portActivePad = PAD_W'(portActive);
  assign portEn        = portActivePad[inPort];

  rx_ts_port_cfg #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .LEN_W(LEN_W), .BASE_MAX_LEN(BASE_MAX_LEN)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPort(cfgPort), .cfgWdata(cfgWdata),
    .commitOk(commitOk), .portActive(portActive),
    .portSkipLen(portSkipLen), .portMaxLen(portMaxLen)
  );

  rx_ts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .outReady(outReady), .portEn(portEn), .hdrLast(hdrLast),
    .inReady(inReady), .outValid(outValid), .commitOk(commitOk), .strobe(strobe)
  );

  rx_ts_dpath #(.DATA_BYTES(DATA_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .ptpTime(ptpTime), .strobe(strobe),
    .inData(inData), .inKeep(inKeep), .inSof(inSof), .inEof(inEof),
    .outData(outData), .outKeep(outKeep), .outSof(outSof), .outEof(outEof),
    .hdrLast(hdrLast)
  );
endmodule

// File: rtl/rx_ts_prepend_chk.sv
module rx_ts_prepend_chk
  import rx_ts_prepend_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int DATA_BYTES   = 2,
  parameter int LEN_W        = 16,
  parameter int BASE_MAX_LEN = 1518
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        inValid,
  input logic                        inReady,
  input logic                        outValid,
  input logic                        outReady,
  input logic [8*DATA_BYTES-1:0]     outData,
  input logic [DATA_BYTES-1:0]       outKeep,
  input logic                        outSof,
  input logic                        outEof,
  input logic [NUM_PORTS*SKIP_W-1:0] portSkipLen,
  input logic [NUM_PORTS*LEN_W-1:0]  portMaxLen
);
  logic inFrame;

  always_ff @(posedge clk) begin
    if (!rstN) inFrame <= 1'b0;
    else if (outValid && outReady) begin
      if (outEof)      inFrame <= 1'b0;
      else if (outSof) inFrame <= 1'b1;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outKeep)
                                 && $stable(outSof) && $stable(outEof)));

  assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outValid && outReady));

  assert_sof_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inFrame && outValid) |-> !outSof);

  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> ($stable(portSkipLen) && $stable(portMaxLen)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pair
    assert_skip_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
      (portSkipLen[p*SKIP_W +: SKIP_W] != '0) |->
        (portSkipLen[p*SKIP_W +: SKIP_W] == SKIP_W'(SKIP_ON)
         && portMaxLen[p*LEN_W +: LEN_W] == LEN_W'(BASE_MAX_LEN + TS_BYTES)));

    assert_len_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
      (portSkipLen[p*SKIP_W +: SKIP_W] == '0) |->
        (portMaxLen[p*LEN_W +: LEN_W] == LEN_W'(BASE_MAX_LEN)));
  end
endmodule

bind rx_ts_prepend rx_ts_prepend_chk #(
  .NUM_PORTS(NUM_PORTS), .DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W), .BASE_MAX_LEN(BASE_MAX_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outKeep(outKeep),
  .outSof(outSof), .outEof(outEof), .portSkipLen(portSkipLen), .portMaxLen(portMaxLen)
);

// File: tb/rx_ts_prepend_tb.sv
module rx_ts_prepend_tb;
  import rx_ts_prepend_pkg::*;

  localparam int NUM_PORTS  = 4;
  localparam int DATA_BYTES = 2;
  localparam int LEN_W      = 16;
  localparam int BASE       = 1518;
  localparam int PORT_W     = 2;
  localparam int DATA_W     = 8 * DATA_BYTES;

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic [63:0]                 ptpTime;
  logic                        cfgWe = 1'b0;
  logic [PORT_W-1:0]           cfgPort = '0;
  logic [15:0]                 cfgWdata = '0;
  logic                        inValid = 1'b0;
  logic                        inReady;
  logic [DATA_W-1:0]           inData = '0;
  logic [DATA_BYTES-1:0]       inKeep = '0;
  logic                        inSof = 1'b0;
  logic                        inEof = 1'b0;
  logic [PORT_W-1:0]           inPort = '0;
  logic                        outValid;
  logic                        outReady = 1'b0;
  logic [DATA_W-1:0]           outData;
  logic [DATA_BYTES-1:0]       outKeep;
  logic                        outSof;
  logic                        outEof;
  logic [NUM_PORTS*4-1:0]      portSkipLen;
  logic [NUM_PORTS*LEN_W-1:0]  portMaxLen;

  rx_ts_prepend #(.NUM_PORTS(NUM_PORTS), .DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W),
                  .BASE_MAX_LEN(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .ptpTime(ptpTime), .cfgWe(cfgWe), .cfgPort(cfgPort),
    .cfgWdata(cfgWdata), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inKeep(inKeep), .inSof(inSof), .inEof(inEof), .inPort(inPort),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outKeep(outKeep),
    .outSof(outSof), .outEof(outEof), .portSkipLen(portSkipLen), .portMaxLen(portMaxLen)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) ptpTime <= 64'h0123_4567_89AB_CDEF;
    else       ptpTime <= ptpTime + 64'h0000_0001_0203_0405;
  end

  int total = 0;
  int bad   = 0;
  bit benchEn [NUM_PORTS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- sink ----------------
  int          readyMode = 0;
  logic [7:0]  actQ[$];
  logic [7:0]  expQ[$];
  int          framesDone = 0;
  int          framesSent = 0;
  bit          sinkBusy = 0;
  bit          sofErr = 0;

  function automatic int keepCount(input logic [DATA_BYTES-1:0] k);
    int n = 0;
    for (int i = 0; i < DATA_BYTES; i++) if (k[i] && n == i) n++;
    return n;
  endfunction

  always @(negedge clk) begin
    case (readyMode)
      0:       outReady = 1'b1;
      1:       outReady = ($urandom_range(0, 2) != 0);
      default: outReady = 1'b0;
    endcase
    #5;
    if (rstN && outValid && outReady) begin
      int n;
      if (outSof) begin
        if (sinkBusy) sofErr = 1;
        sinkBusy = 1;
      end else if (!sinkBusy) sofErr = 1;
      n = outEof ? keepCount(outKeep) : DATA_BYTES;
      for (int i = 0; i < n; i++) actQ.push_back(outData[8*i +: 8]);
      if (outEof) begin
        sinkBusy = 0;
        framesDone++;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic cfg_write(input int port, input logic [15:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgPort = PORT_W'(port); cfgWdata = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic send_frame(input int port, input int len, input bit hdr);
    logic [7:0]  pl[$];
    logic [63:0] ts;
    int beats;
    ts = '0;
    for (int i = 0; i < len; i++) pl.push_back(8'($urandom));
    beats = (len + DATA_BYTES - 1) / DATA_BYTES;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (b == 0); inEof = (b == beats - 1); inPort = PORT_W'(port);
      for (int j = 0; j < DATA_BYTES; j++) begin
        int idx = b * DATA_BYTES + j;
        inData[8*j +: 8] = (idx < len) ? pl[idx] : 8'($urandom);
        inKeep[j]        = (idx < len);
      end
      if (b == 0) ts = ptpTime;
      #5;
      while (!inReady) begin
        @(negedge clk);
        #5;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    expQ.delete();
    if (hdr) for (int k = 0; k < 8; k++) expQ.push_back(ts[63 - 8*k -: 8]);
    for (int i = 0; i < len; i++) expQ.push_back(pl[i]);
    framesSent++;
  endtask

  task automatic finish_frame(input string req);
    bit ok;
    int bad_at;
    while (framesDone < framesSent) @(negedge clk);
    ok = (actQ.size() == expQ.size());
    bad_at = -1;
    if (ok) for (int i = 0; i < expQ.size(); i++)
      if (actQ[i] !== expQ[i] && bad_at < 0) bad_at = i;
    if (bad_at >= 0) begin
      ok = 0;
      check(ok, req, $sformatf("frame byte %0d", bad_at), 64'(actQ[bad_at]), 64'(expQ[bad_at]));
    end else begin
      check(ok, req, "frame byte count", 64'(actQ.size()), 64'(expQ.size()));
    end
    check(!sofErr, "R9", "start marker placement", 64'(sofErr), 64'd0);
    sofErr = 0;
    actQ.delete();
  endtask

  task automatic check_port(input int p, input string req);
    logic [3:0]       expSkip;
    logic [LEN_W-1:0] expLen;
    expSkip = benchEn[p] ? 4'd4 : 4'd0;
    expLen  = benchEn[p] ? LEN_W'(BASE + 8) : LEN_W'(BASE);
    check(portSkipLen[p*4 +: 4] == expSkip, req, $sformatf("skip len port %0d", p),
          64'(portSkipLen[p*4 +: 4]), 64'(expSkip));
    check(portMaxLen[p*LEN_W +: LEN_W] == expLen, req, $sformatf("max len port %0d", p),
          64'(portMaxLen[p*LEN_W +: LEN_W]), 64'(expLen));
  endtask

  task automatic set_en(input int p, input logic [15:0] w, input string req);
    cfg_write(p, w);
    benchEn[p] = w[12];
    repeat (2) @(negedge clk);
    check_port(p, req);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int p = 0; p < NUM_PORTS; p++) benchEn[p] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(outValid == 1'b0, "R10", "outValid after reset", 64'(outValid), 64'd0);
    for (int p = 0; p < NUM_PORTS; p++) check_port(p, "R10");

    // R2 pass-through on a disabled port
    send_frame(0, 7, 0);
    finish_frame("R2");

    // R3 R4 R5 enable, repeat, disable via all-other-bits word
    set_en(1, 16'h1000, "R4");
    check_port(0, "R3");
    set_en(1, 16'h1000, "R5");
    set_en(1, 16'hEFFF, "R3");
    set_en(1, 16'h0000, "R5");
    set_en(1, 16'h1000, "R3");
    check_port(2, "R3");

    // R1 header then data, odd length
    send_frame(1, 5, 1);
    finish_frame("R1");
    // R9 one-byte and exact-beat frames
    send_frame(1, 1, 1);
    finish_frame("R9");
    send_frame(1, 2, 1);
    finish_frame("R9");

    // R7 long frame under random backpressure
    readyMode = 1;
    send_frame(1, 30, 1);
    finish_frame("R7");
    readyMode = 0;

    // R6 disable while the frame is stalled in its header
    readyMode = 2;
    fork
      send_frame(1, 9, 1);
      begin
        repeat (4) @(negedge clk);
        cfg_write(1, 16'h0000);
        repeat (3) @(negedge clk);
        check_port(1, "R6");
        readyMode = 0;
      end
    join
    finish_frame("R6");
    benchEn[1] = 0;
    repeat (3) @(negedge clk);
    check_port(1, "R6");

    // R7 header stalled for many cycles while time advances
    set_en(2, 16'h1000, "R4");
    readyMode = 2;
    fork
      send_frame(2, 6, 1);
      begin
        repeat (12) @(negedge clk);
        readyMode = 0;
      end
    join
    finish_frame("R7");

    // random frames and switch changes
    for (int n = 0; n < 40; n++) begin
      int p;
      if ($urandom_range(0, 3) == 0) begin
        p = $urandom_range(0, NUM_PORTS - 1);
        set_en(p, 16'($urandom), "R5");
      end
      p = $urandom_range(0, NUM_PORTS - 1);
      readyMode = $urandom_range(0, 1);
      send_frame(p, $urandom_range(1, 24), benchEn[p]);
      finish_frame(benchEn[p] ? "R1" : "R2");
      readyMode = 0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule